// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a virtual address into a physical address using a small table of segment descriptors. Each descriptor carries a base address, a limit and a valid flag. The top bits of the virtual address pick a descriptor and the remaining bits are an offset. The block adds the offset to the descriptor's base to form the physical address. It also checks the offset against the limit and checks the descriptor's valid flag. Any failed check raises a fault, and a cause code says which check failed.

The descriptor table is written only through a separate load port, which privileged software drives when it switches context. The request side has no path into the table. A request is presented for one cycle. The result appears on registered outputs in the next cycle and stays there until the next request. The table has eight entries. With the default two-bit segment field, only entries 0 to 3 can be reached from a virtual address.

Top module: `segXlate`

## Requirements
- R1: The segment number is vaddr[15:14] and the offset is vaddr[13:0]; the segment number selects table entry 0 to 3.
- R2: For an accepted access, paddr equals the selected base plus the offset, truncated to 16 bits (wrap-around past 0xFFFF).
- R3: An offset greater than or equal to the limit of a valid segment faults with cause 2'b10; an offset equal to the limit faults and limit-1 passes.
- R4: An access to a segment whose valid flag is clear faults with cause 2'b01, and this cause wins over a limit violation.
- R5: Whenever fault is high, paddr is 0; when fault is low, cause is 2'b00.
- R6: rspValid is high exactly in the cycle after a cycle with reqValid high, and paddr, fault and faultCause take their new values in that same cycle.
- R7: Reset clears every valid flag and drives rspValid, paddr, fault and faultCause to 0; any access after reset with no load faults with cause 2'b01.
- R8: A load with ldEn high writes ldBase, ldLimit and ldValid into entry ldIdx at the clock edge; a request in the same cycle as a load still sees the previous descriptor.
- R9: Loads to entries 4 to 7 have no effect on translation of any virtual address.
- R10: While reqValid is low, paddr, fault and faultCause hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Privileged descriptor load strobe |
| ldIdx | input | 3 | Table entry to load |
| ldBase | input | 16 | Base address to load |
| ldLimit | input | 15 | Segment length to load (legal offsets 0 to limit-1) |
| ldValid | input | 1 | Valid flag to load |
| reqValid | input | 1 | Translation request strobe |
| vaddr | input | 16 | Virtual address |
| rspValid | output | 1 | Result valid, one cycle after request |
| paddr | output | 16 | Physical address, 0 on fault |
| fault | output | 1 | Access error |
| faultCause | output | 2 | 00 none, 01 invalid segment, 10 limit violation |

## Verification
The bench aims at the limit boundary. It tests offsets at limit-1 and at limit, so a design that uses a greater-than compare would let the offset equal to the limit through without a fault. It tests a segment that is both invalid and over its limit. A design with the wrong priority would report a limit violation there, and a design that forgets to zero the address would leak base+offset on a fault. A load and a request for the same entry are issued in one cycle. A design that reads through the write port would return the new base one cycle too early. The bench also writes entries 4 to 7 and checks that no segment changes, and it adds past 0xFFFF to check that the sum wraps.

// File: rtl/segXlatePkg.sv
package segXlatePkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_SEG_OFF = 2'b01,
    CAUSE_RANGE   = 2'b10
  } faultCause_e;

  typedef struct packed {
    logic tblWr;
    logic capture;
  } xlateStrobe_t;
endpackage

// File: rtl/segXlateCtrl.sv
module segXlateCtrl
  import segXlatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ldEn,
  input  logic         reqValid,
  output xlateStrobe_t strobe,
  output logic         rspValid
);
  always_comb begin
    strobe.tblWr   = ldEn;
    strobe.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/segXlateDp.sv
module segXlateDp
  import segXlatePkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_W     = 2,
  parameter int PA_W      = 16,
  parameter int TBL_DEPTH = 8,
  localparam int OFF_W    = VA_W - SEG_W,
  localparam int LIM_W    = OFF_W + 1,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlateStrobe_t     strobe,
  input  logic [IDX_W-1:0] ldIdx,
  input  logic [PA_W-1:0]  ldBase,
  input  logic [LIM_W-1:0] ldLimit,
  input  logic             ldValid,
  input  logic [VA_W-1:0]  vaddr,
  output logic [PA_W-1:0]  paddr,
  output logic             fault,
  output logic [1:0]       faultCause
);
  logic [PA_W-1:0]  baseArr  [TBL_DEPTH];
  logic [LIM_W-1:0] limitArr [TBL_DEPTH];
  logic             validArr [TBL_DEPTH];

  // One register set per descriptor entry
  for (genvar i = 0; i < TBL_DEPTH; i++) begin : gEntry
    logic [PA_W-1:0]  baseQ;
    logic [LIM_W-1:0] limitQ;
    logic             validQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ  <= '0;
        limitQ <= '0;
        validQ <= 1'b0;
      end else if (strobe.tblWr && ldIdx == IDX_W'(i)) begin
        baseQ  <= ldBase;
        limitQ <= ldLimit;
        validQ <= ldValid;
      end
    end
    assign baseArr[i]  = baseQ;
    assign limitArr[i] = limitQ;
    assign validArr[i] = validQ;
  end

  logic [SEG_W-1:0] segNum;
  logic [OFF_W-1:0] offset;
  logic [IDX_W-1:0] rdIdx;
  logic [PA_W-1:0]  selBase;
  logic [LIM_W-1:0] selLimit;
  logic             selValid;
  logic             overLimit;
  logic [PA_W-1:0]  sum;
  faultCause_e      causeNext;

  always_comb begin
    segNum    = vaddr[VA_W-1:OFF_W];
    offset    = vaddr[OFF_W-1:0];
    rdIdx     = IDX_W'(segNum);
    selBase   = baseArr[rdIdx];
    selLimit  = limitArr[rdIdx];
    selValid  = validArr[rdIdx];
    overLimit = {1'b0, offset} >= selLimit;
    sum       = selBase + PA_W'(offset);
    if (!selValid)     causeNext = CAUSE_SEG_OFF;
    else if (overLimit) causeNext = CAUSE_RANGE;
    else               causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr      <= '0;
      fault      <= 1'b0;
      faultCause <= CAUSE_NONE;
    end else if (strobe.capture) begin
      fault      <= causeNext != CAUSE_NONE;
      faultCause <= causeNext;
      paddr      <= (causeNext == CAUSE_NONE) ? sum : '0;
    end
  end
endmodule

// File: rtl/segXlate.sv
module segXlate
  import segXlatePkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_W     = 2,
  parameter int PA_W      = 16,
  parameter int TBL_DEPTH = 8,
  localparam int OFF_W    = VA_W - SEG_W,
  localparam int LIM_W    = OFF_W + 1,
  localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldEn,
  input  logic [IDX_W-1:0] ldIdx,
  input  logic [PA_W-1:0]  ldBase,
  input  logic [LIM_W-1:0] ldLimit,
  input  logic             ldValid,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  vaddr,
  output logic             rspValid,
  output logic [PA_W-1:0]  paddr,
  output logic             fault,
  output logic [1:0]       faultCause
);
  xlateStrobe_t strobe;

  segXlateCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .reqValid(reqValid),
    .strobe(strobe), .rspValid(rspValid)
  );

  segXlateDp #(
    .VA_W(VA_W), .SEG_W(SEG_W), .PA_W(PA_W), .TBL_DEPTH(TBL_DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ldIdx(ldIdx),
    .ldBase(ldBase), .ldLimit(ldLimit), .ldValid(ldValid),
    .vaddr(vaddr), .paddr(paddr), .fault(fault), .faultCause(faultCause)
  );
endmodule

// File: rtl/segXlateChk.sv
module segXlateChk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            rspValid,
  input logic [PA_W-1:0] paddr,
  input logic            fault,
  input logic [1:0]      faultCause
);
  // R5
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> paddr == '0);

  // R5
  cause_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> faultCause == 2'b00);

  // R4
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultCause == 2'b01 || faultCause == 2'b10));

  // R6
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R6
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(paddr) && $stable(fault) && $stable(faultCause)));
endmodule

bind segXlate segXlateChk #(.PA_W(PA_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspValid(rspValid),
  .paddr(paddr), .fault(fault), .faultCause(faultCause)
);

// File: tb/tb_segXlate.sv
module tb_segXlate;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ldEn;
  logic [2:0]  ldIdx;
  logic [15:0] ldBase;
  logic [14:0] ldLimit;
  logic        ldValid;
  logic        reqValid;
  logic [15:0] vaddr;
  logic        rspValid;
  logic [15:0] paddr;
  logic        fault;
  logic [1:0]  faultCause;

  int checks = 0;
  int errors = 0;

  logic [15:0] mBase  [4];
  logic [14:0] mLimit [4];
  logic        mValid [4];

  always #5 clk = ~clk;

  segXlate dut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldIdx(ldIdx), .ldBase(ldBase),
    .ldLimit(ldLimit), .ldValid(ldValid), .reqValid(reqValid), .vaddr(vaddr),
    .rspValid(rspValid), .paddr(paddr), .fault(fault), .faultCause(faultCause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [15:0] b, input logic [14:0] l, input logic v);
    @(negedge clk);
    ldEn = 1'b1; ldIdx = 3'(idx); ldBase = b; ldLimit = l; ldValid = v;
    @(negedge clk);
    ldEn = 1'b0;
    if (idx < 4) begin
      mBase[idx] = b; mLimit[idx] = l; mValid[idx] = v;
    end
  endtask

  // Model computed from R1..R5
  task automatic expect_of(input logic [15:0] va, output logic [15:0] ePa,
                           output logic eF, output logic [1:0] eC);
    int s;
    logic [13:0] off;
    s = int'(va[15:14]);
    off = va[13:0];
    if (!mValid[s]) begin
      eC = 2'b01; eF = 1'b1; ePa = 16'h0;
    end else if ({1'b0, off} >= mLimit[s]) begin
      eC = 2'b10; eF = 1'b1; ePa = 16'h0;
    end else begin
      eC = 2'b00; eF = 1'b0; ePa = mBase[s] + {2'b00, off};
    end
  endtask

  task automatic access(input string req, input logic [15:0] va);
    logic [15:0] ePa;
    logic eF;
    logic [1:0] eC;
    expect_of(va, ePa, eF, eC);
    @(negedge clk);
    reqValid = 1'b1; vaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " rspValid"}, 32'(rspValid), 32'd1);
    check({req, " paddr"}, 32'(paddr), 32'(ePa));
    check({req, " fault"}, 32'(fault), 32'(eF));
    check({req, " cause"}, 32'(faultCause), 32'(eC));
  endtask

  task automatic tResetState();
    check("R7 rspValid after reset", 32'(rspValid), 32'd0);
    check("R7 paddr after reset", 32'(paddr), 32'd0);
    check("R7 fault after reset", 32'(fault), 32'd0);
    access("R7 access before any load", 16'h0010);
    check("R7 cause invalid", 32'(faultCause), 32'd1);
  endtask

  task automatic tLoadRef();
    load(0, 16'h4000, 15'h0800, 1'b1);
    load(1, 16'h4800, 15'h1400, 1'b1);
    load(2, 16'hF000, 15'h1000, 1'b1);
    load(3, 16'h0000, 15'h3000, 1'b1);
  endtask

  task automatic tTranslate();
    access("R2 seg0 off 0x123", 16'h0123);
    check("R2 seg0 value", 32'(paddr), 32'h4123);
    access("R1 seg1 off 0x13FF", 16'h53FF);
    check("R1 seg1 value", 32'(paddr), 32'h5BFF);
    access("R2 seg2 top", 16'h8FFF);
    check("R2 seg2 value", 32'(paddr), 32'hFFFF);
    access("R1 seg3 off 0", 16'hC000);
  endtask

  task automatic tLimit();
    access("R3 seg0 limit-1", 16'h07FF);
    check("R3 limit-1 no fault", 32'(fault), 32'd0);
    access("R3 seg0 at limit", 16'h0800);
    check("R3 at limit cause", 32'(faultCause), 32'd2);
    access("R3 seg3 far over", 16'hFFFF);
  endtask

  task automatic tInvalid();
    load(2, 16'hF000, 15'h1000, 1'b0);
    access("R4 invalid in range", 16'h8001);
    access("R4 invalid and over limit", 16'h9000);
    check("R4 priority cause", 32'(faultCause), 32'd1);
    check("R5 paddr zero on fault", 32'(paddr), 32'd0);
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    ldEn = 1'b1; ldIdx = 3'd1; ldBase = 16'h2000; ldLimit = 15'h1400; ldValid = 1'b1;
    reqValid = 1'b1; vaddr = 16'h4010;
    @(negedge clk);
    ldEn = 1'b0; reqValid = 1'b0;
    check("R8 same-cycle sees old base", 32'(paddr), 32'h4810);
    mBase[1] = 16'h2000;
    access("R8 after load new base", 16'h4010);
    check("R8 new value", 32'(paddr), 32'h2010);
  endtask

  task automatic tHighEntries();
    for (int i = 4; i < 8; i++) load(i, 16'h1111, 15'h0001, 1'b0);
    access("R9 seg0 unaffected", 16'h0004);
    access("R9 seg1 unaffected", 16'h4004);
    access("R9 seg3 unaffected", 16'hC004);
    check("R9 seg3 value", 32'(paddr), 32'h0004);
  endtask

  task automatic tWrapAndHold();
    load(3, 16'hF000, 15'h3000, 1'b1);
    access("R2 wrap past 0xFFFF", 16'hE000);
    check("R2 wrapped value", 32'(paddr), 32'h1000);
    repeat (3) @(negedge clk);
    vaddr = 16'h0000;
    load(3, 16'h0000, 15'h0001, 1'b0);
    check("R10 paddr held", 32'(paddr), 32'h1000);
    check("R10 fault held", 32'(fault), 32'd0);
    check("R6 rspValid idle", 32'(rspValid), 32'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mBase[i] = '0; mLimit[i] = '0; mValid[i] = 1'b0;
    end
    rstN = 1'b0; ldEn = 1'b0; ldIdx = '0; ldBase = '0; ldLimit = '0; ldValid = 1'b0;
    reqValid = 1'b0; vaddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tResetState();
    tLoadRef();
    tTranslate();
    tLimit();
    tInvalid();
    tSameCycle();
    tHighEntries();
    tWrapAndHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule